// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control half of a single DMA channel. Software describes work as a chain of descriptors in memory. Each descriptor is eight 32-bit words on a 32-byte boundary. The sequencer reads the descriptor one word at a time through a simple read port. It latches the fields that describe a transfer and starts an external data-movement engine with a one-cycle start pulse.

When the engine reports that it has finished, the sequencer loads the descriptor's link word as its new current pointer and fetches the next descriptor. A link of zero stops the chain. Software aborts the block in flight by writing a control bit; the channel then moves on to the next descriptor.

A small register window gives software the channel status, the current descriptor pointer and the latched descriptor fields. Status flags are raised by events and cleared by writing one. The interrupt flag drives the `irq` output. A fetch that returns an error response halts the channel, and a reset write returns it to idle on the next clock edge.

Top module: `dma_chain_seq`

## Requirements
- R1: After `rstN` is released, the status word reads 0, the current pointer reads 0, `memReqValid`, `engStart` and `irq` are low.
- R2: Writing status with bit 0 set while the channel is idle sets active (status bit 0). The channel then reads the eight descriptor words at pointer+0, +4 … +28 in ascending order, and starts one read only after the previous one has returned.
- R3: The low five bits of any descriptor pointer are ignored. This holds for a pointer written at offset 0x04, which reads back with them cleared, and for a link word fetched from memory.
- R4: One cycle after the eighth word returns, `engStart` pulses for one cycle. At that time `engInfo`, `engSrc`, `engDst`, `engLen` and `engStride` carry descriptor words 0, 1, 2, 3 and 4.
- R5: On `engDone` the link word (descriptor word 5) becomes the current pointer and fetching restarts there. If the link with its low five bits cleared is zero, end (status bit 1) is set, active clears and the channel stops.
- R6: If bit 0 of the info word is set, the interrupt flag (status bit 2) is set when that block completes through `engDone`. `irq` follows the interrupt flag.
- R7: Writing 1 to status bits 1, 2 or 8 clears end, interrupt or error respectively. Writing 0 to them leaves them unchanged.
- R8: An error response (`memRspErr`) during a descriptor fetch sets error (status bit 8), clears active and starts no transfer.
- R9: Writing status with bit 30 set while a transfer is in flight pulses `engAbort` in that cycle and ends the block without raising interrupt. The channel then follows the link as in R5.
- R10: Writing status with bit 31 set clears every flag, the pointer and the latched fields, and returns the channel to idle at the next clock edge.
- R11: Writes to the pointer at offset 0x04 are ignored while the channel is active.
- R12: Register window (byte offsets, bits [1:0] ignored): 0x00 status, 0x04 current pointer, 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C link. Other offsets and unlisted status bits read 0, and bits 31, 30 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| memReqValid | output | 1 | One-cycle descriptor word read request |
| memReqAddr | output | 32 | Byte address of the requested word |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response data |
| memRspErr | input | 1 | Read response carries an error |
| engStart | output | 1 | Transfer start pulse to the data engine |
| engAbort | output | 1 | Transfer abort pulse to the data engine |
| engInfo | output | 32 | Latched info word |
| engSrc | output | 32 | Latched source address |
| engDst | output | 32 | Latched destination address |
| engLen | output | 32 | Latched transfer length |
| engStride | output | 32 | Latched stride word |
| engDone | input | 1 | Data engine reports the transfer finished |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions take for granted that memory answers only a request the channel actually made. They also assume it returns exactly one response per request, and that `engDone` arrives only while a transfer started by `engStart` is in flight. The bench's memory model queues at most one pending response and replies one cycle after each request. Its engine model raises `engDone` only a set number of cycles after a start, or never when the latency is zero for the abort case. Stray responses after a reset write land while the channel is idle, where the sequencer discards them.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // status bit positions
  localparam int STAT_RESET  = 31;
  localparam int STAT_ABORT  = 30;
  localparam int STAT_ERROR  = 8;
  localparam int STAT_INT    = 2;
  localparam int STAT_END    = 1;
  localparam int STAT_ACTIVE = 0;

  // info word bit enabling the completion interrupt
  localparam int INFO_IRQ_EN = 0;

  // index width for a descriptor word counter (sized for up to 8 words)
  localparam int WIDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_WAIT   = 3'd2,
    ST_LAUNCH = 3'd3,
    ST_BUSY   = 3'd4
  } seqState_t;

  typedef struct packed {
    logic              wordLoad;
    logic [WIDX_W-1:0] wordIdx;
    logic              fetchFail;
    logic              blockDone;
    logic              blockAbort;
    logic              advance;
    logic              chainEnd;
  } seqStrobe_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CB_WORDS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swStart,
  input  logic       swAbort,
  input  logic       swReset,
  input  logic       memRspValid,
  input  logic       memRspErr,
  input  logic       engDone,
  input  logic       nextIsZero,
  output seqStrobe_t stb,
  output seqState_t  stateQ,
  output logic       memReqValid,
  output logic       engStart,
  output logic       engAbort
);

  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(CB_WORDS - 1);

  logic [WIDX_W-1:0] idxQ;
  seqState_t         stateD;
  logic [WIDX_W-1:0] idxD;
  logic              rspOk;
  logic              rspBad;

  assign rspOk  = (stateQ == ST_WAIT) && memRspValid && !memRspErr;
  assign rspBad = (stateQ == ST_WAIT) && memRspValid && memRspErr;

  assign memReqValid = (stateQ == ST_REQ);
  assign engStart    = (stateQ == ST_LAUNCH);
  assign engAbort    = (stateQ == ST_BUSY) && swAbort;

  always_comb begin
    stb            = '0;
    stb.wordLoad   = rspOk;
    stb.wordIdx    = idxQ;
    stb.fetchFail  = rspBad;
    stb.blockAbort = (stateQ == ST_BUSY) && swAbort;
    stb.blockDone  = (stateQ == ST_BUSY) && engDone && !swAbort;
    stb.advance    = stb.blockAbort || stb.blockDone;
    stb.chainEnd   = stb.advance && nextIsZero;
  end

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (swStart) begin
          stateD = ST_REQ;
          idxD   = '0;
        end
      end
      ST_REQ: stateD = ST_WAIT;
      ST_WAIT: begin
        if (rspBad) begin
          stateD = ST_IDLE;
        end else if (rspOk) begin
          if (idxQ == LAST_IDX) begin
            stateD = ST_LAUNCH;
          end else begin
            idxD   = idxQ + 1'b1;
            stateD = ST_REQ;
          end
        end
      end
      ST_LAUNCH: stateD = ST_BUSY;
      ST_BUSY: begin
        if (stb.advance) begin
          stateD = nextIsZero ? ST_IDLE : ST_REQ;
          idxD   = '0;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || swReset) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CB_WORDS = 8,
  parameter int REG_AW   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] memRspData,
  input  seqStrobe_t        stb,
  output logic              swStart,
  output logic              swAbort,
  output logic              swReset,
  output logic              nextIsZero,
  output logic [DATA_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] engInfo,
  output logic [DATA_W-1:0] engSrc,
  output logic [DATA_W-1:0] engDst,
  output logic [DATA_W-1:0] engLen,
  output logic [DATA_W-1:0] engStride,
  output logic              activeFlag,
  output logic              endFlag,
  output logic              intFlag,
  output logic              errFlag
);

  localparam int IDX_W     = $clog2(CB_WORDS);
  localparam int ALIGN_W   = IDX_W + 2;
  localparam int FIELD_CNT = CB_WORDS - 2;
  localparam int F_INFO    = 0;
  localparam int F_SRC     = 1;
  localparam int F_DST     = 2;
  localparam int F_LEN     = 3;
  localparam int F_STRIDE  = 4;
  localparam int F_LINK    = 5;
  localparam int SEL_W     = REG_AW - 2;

  logic [DATA_W-1:0] cbAddrQ;
  logic [DATA_W-1:0] fieldQ [FIELD_CNT];
  logic [SEL_W-1:0]  wordSel;
  logic              wrStatus;
  logic              wrPtr;
  logic [DATA_W-1:0] linkAligned;

  assign wordSel  = regAddr[REG_AW-1:2];
  assign wrStatus = regWrEn && (wordSel == SEL_W'(0));
  assign wrPtr    = regWrEn && (wordSel == SEL_W'(1));

  assign swReset = wrStatus && regWrData[STAT_RESET];
  assign swAbort = wrStatus && regWrData[STAT_ABORT] && !swReset;
  assign swStart = wrStatus && regWrData[STAT_ACTIVE] && !activeFlag && !swReset;

  assign linkAligned = {fieldQ[F_LINK][DATA_W-1:ALIGN_W], ALIGN_W'(0)};
  assign nextIsZero  = (linkAligned == '0);

  assign memReqAddr = {cbAddrQ[DATA_W-1:ALIGN_W], stb.wordIdx[IDX_W-1:0], 2'b00};

  genvar g;
  generate
    for (g = 0; g < FIELD_CNT; g++) begin : g_field
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN || swReset) begin
          q <= '0;
        end else if (stb.wordLoad && (stb.wordIdx == WIDX_W'(g))) begin
          q <= memRspData;
        end
      end
      assign fieldQ[g] = q;
    end
  endgenerate

  assign engInfo   = fieldQ[F_INFO];
  assign engSrc    = fieldQ[F_SRC];
  assign engDst    = fieldQ[F_DST];
  assign engLen    = fieldQ[F_LEN];
  assign engStride = fieldQ[F_STRIDE];

  always_ff @(posedge clk) begin
    if (!rstN || swReset) begin
      cbAddrQ    <= '0;
      activeFlag <= 1'b0;
      endFlag    <= 1'b0;
      intFlag    <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      if (stb.advance) begin
        cbAddrQ <= linkAligned;
      end else if (wrPtr && !activeFlag) begin
        cbAddrQ <= {regWrData[DATA_W-1:ALIGN_W], ALIGN_W'(0)};
      end

      if (swStart) begin
        activeFlag <= 1'b1;
      end else if (stb.fetchFail || stb.chainEnd) begin
        activeFlag <= 1'b0;
      end

      if (stb.chainEnd) begin
        endFlag <= 1'b1;
      end else if (wrStatus && regWrData[STAT_END]) begin
        endFlag <= 1'b0;
      end

      if (stb.blockDone && fieldQ[F_INFO][INFO_IRQ_EN]) begin
        intFlag <= 1'b1;
      end else if (wrStatus && regWrData[STAT_INT]) begin
        intFlag <= 1'b0;
      end

      if (stb.fetchFail) begin
        errFlag <= 1'b1;
      end else if (wrStatus && regWrData[STAT_ERROR]) begin
        errFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (wordSel == SEL_W'(0)) begin
      regRdData[STAT_ERROR]  = errFlag;
      regRdData[STAT_INT]    = intFlag;
      regRdData[STAT_END]    = endFlag;
      regRdData[STAT_ACTIVE] = activeFlag;
    end else if (wordSel == SEL_W'(1)) begin
      regRdData = cbAddrQ;
    end else if (int'(wordSel) < FIELD_CNT + 2) begin
      regRdData = fieldQ[int'(wordSel) - 2];
    end
  end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CB_WORDS = 8,
  parameter int REG_AW   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReqValid,
  output logic [DATA_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              engStart,
  output logic              engAbort,
  output logic [DATA_W-1:0] engInfo,
  output logic [DATA_W-1:0] engSrc,
  output logic [DATA_W-1:0] engDst,
  output logic [DATA_W-1:0] engLen,
  output logic [DATA_W-1:0] engStride,
  input  logic              engDone,
  output logic              irq
);

  seqStrobe_t stb;
  seqState_t  ctrlState;
  logic       swStart;
  logic       swAbort;
  logic       swReset;
  logic       nextIsZero;
  logic       activeFlag;
  logic       endFlag;
  logic       intFlag;
  logic       errFlag;

  dma_seq_ctrl #(
    .CB_WORDS(CB_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swStart    (swStart),
    .swAbort    (swAbort),
    .swReset    (swReset),
    .memRspValid(memRspValid),
    .memRspErr  (memRspErr),
    .engDone    (engDone),
    .nextIsZero (nextIsZero),
    .stb        (stb),
    .stateQ     (ctrlState),
    .memReqValid(memReqValid),
    .engStart   (engStart),
    .engAbort   (engAbort)
  );

  dma_seq_dpath #(
    .DATA_W  (DATA_W),
    .CB_WORDS(CB_WORDS),
    .REG_AW  (REG_AW)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .memRspData(memRspData),
    .stb       (stb),
    .swStart   (swStart),
    .swAbort   (swAbort),
    .swReset   (swReset),
    .nextIsZero(nextIsZero),
    .memReqAddr(memReqAddr),
    .engInfo   (engInfo),
    .engSrc    (engSrc),
    .engDst    (engDst),
    .engLen    (engLen),
    .engStride (engStride),
    .activeFlag(activeFlag),
    .endFlag   (endFlag),
    .intFlag   (intFlag),
    .errFlag   (errFlag)
  );

  assign irq = intFlag;

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input seqState_t         ctrlState,
  input logic              activeFlag,
  input logic              endFlag,
  input logic              intFlag,
  input logic              errFlag,
  input logic              swReset,
  input logic              memReqValid,
  input logic [DATA_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              memRspErr,
  input logic              engStart,
  input logic              engDone
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
    end else if (memReqValid) begin
      outstanding <= 1'b1;
    end else if (memRspValid || !activeFlag) begin
      outstanding <= 1'b0;
    end
  end

  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);

  // R2
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00) && activeFlag);

  // R2
  busy_matches_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState != ST_IDLE) == activeFlag);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R4
  start_while_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> activeFlag);

  // R5
  end_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> !activeFlag);

  // R6
  int_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> $past(engDone));

  // R8
  fetch_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && memRspErr && ctrlState == ST_WAIT && !swReset)
      |=> errFlag && !activeFlag);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> !activeFlag && !endFlag && !intFlag && !errFlag && !memReqValid);

endmodule

bind dma_chain_seq dma_chain_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlState  (ctrlState),
  .activeFlag (activeFlag),
  .endFlag    (endFlag),
  .intFlag    (intFlag),
  .errFlag    (errFlag),
  .swReset    (swReset),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .memRspValid(memRspValid),
  .memRspErr  (memRspErr),
  .engStart   (engStart),
  .engDone    (engDone)
);

// File: tb/dma_chain_seq_test.sv
`timescale 1ns/1ps
module dma_chain_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        memRspErr = 1'b0;
  logic        engStart;
  logic        engAbort;
  logic [31:0] engInfo, engSrc, engDst, engLen, engStride;
  logic        engDone = 1'b0;
  logic        irq;

  dma_chain_seq uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .engStart(engStart), .engAbort(engAbort), .engInfo(engInfo),
    .engSrc(engSrc), .engDst(engDst), .engLen(engLen), .engStride(engStride),
    .engDone(engDone), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] mem [64];
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  bit          pend = 0;
  logic [31:0] pendAddr = '0;
  int          reqCount = 0;
  int          seqErr = 0;
  int          expIdx = 0;

  int          engLat = 3;
  int          engCnt = 0;
  bit          engBusy = 0;
  int          starts = 0;
  bit          capFirst = 0;
  logic [31:0] firstInfo, firstSrc, firstDst, firstLen, firstStride, lastSrc;

  function automatic logic [31:0] infoOf(input logic [31:0] b);
    return (b == 32'h20 || b == 32'h80) ? 32'h1 : 32'h0;
  endfunction

  function automatic logic [31:0] linkOf(input logic [31:0] b);
    case (b)
      32'h20:  return 32'h40;
      32'h40:  return 32'h1F;
      32'h80:  return 32'h6F;
      default: return 32'h0;
    endcase
  endfunction

  // memory responder: one reply, one cycle after each request
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hBAD0_0000 + i;
    for (int b = 1; b <= 4; b++) begin
      logic [31:0] a;
      a = 32'(b * 32);
      mem[a[7:2] + 0] = infoOf(a);
      mem[a[7:2] + 1] = 32'h1000 + a;
      mem[a[7:2] + 2] = 32'h2000 + a;
      mem[a[7:2] + 3] = 32'd16 + a;
      mem[a[7:2] + 4] = {a[15:0], a[15:0]};
      mem[a[7:2] + 5] = linkOf(a);
    end
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspErr   = 1'b0;
      if (pend) begin
        memRspValid = 1'b1;
        memRspData  = mem[pendAddr[7:2]];
        memRspErr   = (pendAddr == errAddr);
        pend = 0;
      end
      if (memReqValid) begin
        pend = 1;
        pendAddr = memReqAddr;
        reqCount++;
        if (int'(memReqAddr[4:2]) != expIdx) seqErr++;
        expIdx = (expIdx + 1) % 8;
      end
    end
  end

  // data engine model
  initial begin
    forever begin
      @(negedge clk);
      engDone = 1'b0;
      if (engStart) begin
        starts++;
        lastSrc = engSrc;
        if (capFirst) begin
          firstInfo = engInfo; firstSrc = engSrc; firstDst = engDst;
          firstLen = engLen; firstStride = engStride;
          capFirst = 0;
        end
        engCnt = engLat;
        engBusy = 1;
      end else if (engBusy && engCnt != 0) begin
        engCnt--;
        if (engCnt == 0) begin
          engDone = 1'b1;
          engBusy = 0;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      regRead(6'h00, s);
      if (s[0] == 1'b0) return;
    end
  endtask

  // start pointer, blocks run, irq expected, source of last block
  localparam logic [68:0] VECS [4] = '{
    {32'h0000_0020, 4'd2, 1'b1, 32'h0000_1040},
    {32'h0000_0060, 4'd1, 1'b0, 32'h0000_1060},
    {32'h0000_0080, 4'd2, 1'b1, 32'h0000_1060},
    {32'h0000_0047, 4'd1, 1'b0, 32'h0000_1040}
  };

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(6'h00, rd); check("R1 status", rd, 32'h0);
    regRead(6'h04, rd); check("R1 pointer", rd, 32'h0);
    check("R1 memReqValid", {31'b0, memReqValid}, 32'h0);
    check("R1 engStart", {31'b0, engStart}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // table walk: R2 R3 R4 R5 R6
    foreach (VECS[v]) begin
      logic [31:0] sp, base;
      int nb, s0, q0;
      sp   = VECS[v][68:37];
      nb   = int'(VECS[v][36:33]);
      base = {sp[31:5], 5'b0};
      regWrite(6'h04, sp | 32'h3);
      regRead(6'h04, rd); check("R3 pointer masked", rd, base);
      s0 = starts; q0 = reqCount; capFirst = 1;
      regWrite(6'h00, 32'h1);
      waitIdle();
      check("R5 blocks run", 32'(starts - s0), 32'(nb));
      check("R2 word reads", 32'(reqCount - q0), 32'(nb * 8));
      check("R2 word order", 32'(seqErr), 32'h0);
      check("R4 info", firstInfo, infoOf(base));
      check("R4 src", firstSrc, 32'h1000 + base);
      check("R4 dst", firstDst, 32'h2000 + base);
      check("R4 len", firstLen, 32'd16 + base);
      check("R4 stride", firstStride, {base[15:0], base[15:0]});
      check("R5 last src", lastSrc, VECS[v][31:0]);
      regRead(6'h00, rd);
      check("R5 end set, active clear", rd, {29'b0, VECS[v][32], 2'b10});
      check("R6 irq pin", {31'b0, irq}, {31'b0, VECS[v][32]});
      regRead(6'h04, rd); check("R5 pointer after end", rd, 32'h0);
      regWrite(6'h00, 32'h106);
    end

    // R7 write-one-to-clear
    regWrite(6'h04, 32'h20);
    regWrite(6'h00, 32'h1);
    waitIdle();
    regWrite(6'h00, 32'h0);
    regRead(6'h00, rd); check("R7 zero write keeps flags", rd, 32'h6);
    regWrite(6'h00, 32'h2);
    regRead(6'h00, rd); check("R7 clear end only", rd, 32'h4);
    regWrite(6'h00, 32'h4);
    regRead(6'h00, rd); check("R7 clear interrupt", rd, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);

    // R8 fetch error on word 2 of block 0x60
    begin
      int s0;
      errAddr = 32'h68;
      s0 = starts;
      regWrite(6'h04, 32'h60);
      regWrite(6'h00, 32'h1);
      waitIdle();
      regRead(6'h00, rd); check("R8 error set, active clear", rd, 32'h100);
      check("R8 no transfer", 32'(starts - s0), 32'h0);
      errAddr = 32'hFFFF_FFFF;
      expIdx = 0;
      regWrite(6'h00, 32'h100);
      regRead(6'h00, rd); check("R7 clear error", rd, 32'h0);
    end

    // R9 abort, R11 pointer write ignored, R12 window
    begin
      int s0;
      engLat = 0;
      s0 = starts;
      regWrite(6'h04, 32'h80);
      regWrite(6'h00, 32'h1);
      for (int i = 0; i < 200 && starts == s0; i++) @(negedge clk);
      regRead(6'h04, rd); check("R12 pointer at 0x04", rd, 32'h80);
      regRead(6'h1C, rd); check("R12 link at 0x1C", rd, 32'h6F);
      regRead(6'h08, rd); check("R12 info at 0x08", rd, 32'h1);
      regRead(6'h0C, rd); check("R12 src at 0x0C", rd, 32'h1080);
      regRead(6'h18, rd); check("R12 stride at 0x18", rd, 32'h0080_0080);
      regRead(6'h24, rd); check("R12 unmapped offset", rd, 32'h0);
      regWrite(6'h04, 32'h40);
      regRead(6'h04, rd); check("R11 pointer write ignored", rd, 32'h80);
      @(negedge clk);
      regAddr = 6'h00; regWrData = 32'h4000_0000; regWrEn = 1'b1;
      #1 check("R9 engAbort pulse", {31'b0, engAbort}, 32'h1);
      engLat = 3;
      @(negedge clk);
      regWrEn = 1'b0;
      waitIdle();
      check("R9 moved to next block", 32'(starts - s0), 32'h2);
      check("R9 last src", lastSrc, 32'h1060);
      regRead(6'h00, rd); check("R9 no interrupt from aborted block", rd, 32'h2);
      regWrite(6'h00, 32'h2);
    end

    // R10 software reset mid-fetch
    regWrite(6'h04, 32'h20);
    regWrite(6'h00, 32'h1);
    repeat (3) @(negedge clk);
    regWrite(6'h00, 32'h8000_0000);
    #1 check("R10 no request after reset", {31'b0, memReqValid}, 32'h0);
    regRead(6'h00, rd); check("R10 status cleared", rd, 32'h0);
    regRead(6'h04, rd); check("R10 pointer cleared", rd, 32'h0);
    regRead(6'h08, rd); check("R10 fields cleared", rd, 32'h0);
    repeat (4) @(negedge clk);
    regRead(6'h00, rd); check("R10 stays idle", rd, 32'h0);

    finishRun();
  end

endmodule